// File: doc/BRIEF.md
# Receive Holding Register with Status Flags

This block is the receive-side register logic of a memory-mapped serial port. It sits between a bit deserializer and the register file. It holds exactly one received byte and keeps a receive level count next to it. From that state it drives three status flags: full, empty and idle. The deserializer presents each finished byte with a valid strobe. The block answers with a ready signal, and a byte is taken only in a cycle where both are high. While the single slot is occupied, ready stays low, so an unread byte is never replaced by a newer one.

Software drains the slot by reading the data register, which the bus logic signals with a one-cycle read strobe. The level count is also presented in a packed FIFO-status word next to a transmit level supplied from outside. Drivers written for a deeper queue can therefore poll a level field instead of the flags. A receive-reset control pulse empties the slot logically, and a device reset brings everything to its idle state.

Top module: `uart_rx_hold`

## Requirements
- R1: `rx_ready_o` is high only when `rx_en_i` is high, `flag_full_o` is low and `rx_rst_i` is low.
- R2: A byte is accepted when `rx_valid_i` and `rx_ready_o` are both high. From the next cycle on, `flag_full_o` is 1, `flag_empty_o` and `flag_idle_o` are 0, the receive level is one higher, and `rd_data_o` shows the accepted byte.
- R3: While `flag_full_o` is 1, no byte is accepted, and `rd_data_o` keeps the byte already held, whatever `rx_valid_i` and `rx_byte_i` do.
- R4: A read strobe consumes a byte when `rx_en_i` is 1, the level is above zero and `rx_rst_i` is 0. From the next cycle on, the level is one lower and `flag_full_o` is 0.
- R5: When a consuming read brings the level to zero, `flag_empty_o` and `flag_idle_o` are 1 from the next cycle on.
- R6: A read strobe with `rx_en_i` at 0, or with the level at zero, changes neither the level nor any flag. `rd_data_o` always shows the held byte.
- R7: In `fifo_status_o`, bits [4:0] carry the receive level and bits [20:16] carry `tx_level_i`. All other bits are 0. Both fields are combinational from their sources.
- R8: A cycle with `rx_rst_i` high makes the level 0, `flag_full_o` 0, and `flag_empty_o` and `flag_idle_o` 1 from the next cycle on. It takes precedence over an incoming byte or a read in the same cycle, and the held byte stays unchanged.
- R9: After `rst`, the level is 0, `flag_full_o` is 0, `flag_empty_o` and `flag_idle_o` are 1, and `rd_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high device reset |
| rx_valid_i | input | 1 | Deserializer has a finished byte |
| rx_byte_i | input | 8 | Byte offered by the deserializer |
| rx_ready_o | output | 1 | Block can take a byte this cycle |
| rd_data_strobe_i | input | 1 | Bus read of the receive data register |
| rx_en_i | input | 1 | Receive enable control bit |
| rx_rst_i | input | 1 | Receive-reset pulse from a FIFO control write |
| tx_level_i | input | 5 | Transmit level to report in the status word |
| rd_data_o | output | 8 | Held byte, returned by a data register read |
| flag_full_o | output | 1 | Slot occupied |
| flag_empty_o | output | 1 | Slot empty |
| flag_idle_o | output | 1 | Receiver side idle (no unread byte) |
| fifo_status_o | output | 32 | Packed receive and transmit level fields |

## Verification
The main function is driven first with a clean sequence: fill, then drain. After that come bytes offered while the slot is full, which separates back-pressure from overwriting. Reads are issued at level zero and with receive disabled, which separates a consuming read from one that is ignored. Receive-reset pulses are placed in the same cycle as an incoming byte or a read, which shows that the reset takes precedence. A long stretch of random valid, read, enable and reset activity with changing transmit levels is then compared each cycle against a behavioural model. This covers the interleavings that the directed steps miss.

// File: rtl/uart_rxh_pkg.sv
package uart_rxh_pkg;

    localparam int RXH_DATA_W = 8;
    localparam int RXH_LVL_W  = 5;
    localparam int RXH_STAT_W = 32;
    localparam int RXH_RX_LSB = 0;
    localparam int RXH_TX_LSB = 16;
    localparam int RXH_DEPTH  = 1;

    typedef struct packed {
        logic full;
        logic empty;
        logic idle;
    } rxh_flags_t;

    localparam rxh_flags_t RXH_FLAGS_IDLE = '{full: 1'b0, empty: 1'b1, idle: 1'b1};
    localparam rxh_flags_t RXH_FLAGS_LOADED = '{full: 1'b1, empty: 1'b0, idle: 1'b0};

    typedef enum logic [1:0] {
        LVL_HOLD = 2'd0,
        LVL_INC  = 2'd1,
        LVL_DEC  = 2'd2,
        LVL_CLR  = 2'd3
    } rxh_lvl_op_e;

    function automatic rxh_lvl_op_e rxh_pick_op(input logic clr, input logic inc, input logic dec);
        if (clr)
            return LVL_CLR;
        else if (inc && !dec)
            return LVL_INC;
        else if (dec && !inc)
            return LVL_DEC;
        else
            return LVL_HOLD;
    endfunction

endpackage

// File: rtl/rxh_level_ctr.sv
module rxh_level_ctr
    import uart_rxh_pkg::*;
#(
    parameter int LVL_W = RXH_LVL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             inc_i,
    input  logic             dec_i,
    output logic [LVL_W-1:0] level_o,
    output logic             nonzero_o,
    output logic             to_zero_o
);
    localparam logic [LVL_W-1:0] ONE = LVL_W'(1);

    logic [LVL_W-1:0] level_q;
    rxh_lvl_op_e      op;

    assign op = rxh_pick_op(clr_i, inc_i, dec_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
        end else begin
            case (op)
                LVL_CLR: level_q <= '0;
                LVL_INC: level_q <= level_q + ONE;
                LVL_DEC: level_q <= level_q - ONE;
                default: level_q <= level_q;
            endcase
        end
    end

    assign level_o   = level_q;
    assign nonzero_o = (level_q != '0);
    assign to_zero_o = (op == LVL_DEC) && (level_q == ONE);
endmodule

// File: rtl/rxh_flag_reg.sv
module rxh_flag_reg
    import uart_rxh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr_i,
    input  logic       load_i,
    input  logic       drain_i,
    input  logic       last_i,
    output rxh_flags_t flags_o
);
    rxh_flags_t flags_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            flags_q <= RXH_FLAGS_IDLE;
        end else if (load_i) begin
            flags_q <= RXH_FLAGS_LOADED;
        end else if (drain_i) begin
            flags_q.full <= 1'b0;
            if (last_i) begin
                flags_q.empty <= 1'b1;
                flags_q.idle  <= 1'b1;
            end
        end
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/rxh_data_reg.sv
module rxh_data_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] dout_o
);
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst)
            data_q <= '0;
        else if (load_i)
            data_q <= din_i;
    end

    assign dout_o = data_q;
endmodule

// File: rtl/rxh_status_pack.sv
module rxh_status_pack #(
    parameter int LVL_W  = 5,
    parameter int STAT_W = 32,
    parameter int RX_LSB = 0,
    parameter int TX_LSB = 16
) (
    input  logic [LVL_W-1:0]  rx_level_i,
    input  logic [LVL_W-1:0]  tx_level_i,
    output logic [STAT_W-1:0] status_o
);
    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
        if (b >= RX_LSB && b < RX_LSB + LVL_W) begin : g_rx
            assign status_o[b] = rx_level_i[b - RX_LSB];
        end else if (b >= TX_LSB && b < TX_LSB + LVL_W) begin : g_tx
            assign status_o[b] = tx_level_i[b - TX_LSB];
        end else begin : g_zero
            assign status_o[b] = 1'b0;
        end
    end
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
    import uart_rxh_pkg::*;
#(
    parameter int DATA_W = RXH_DATA_W,
    parameter int LVL_W  = RXH_LVL_W,
    parameter int STAT_W = RXH_STAT_W,
    parameter int RX_LSB = RXH_RX_LSB,
    parameter int TX_LSB = RXH_TX_LSB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid_i,
    input  logic [DATA_W-1:0] rx_byte_i,
    output logic              rx_ready_o,
    input  logic              rd_data_strobe_i,
    input  logic              rx_en_i,
    input  logic              rx_rst_i,
    input  logic [LVL_W-1:0]  tx_level_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              flag_full_o,
    output logic              flag_empty_o,
    output logic              flag_idle_o,
    output logic [STAT_W-1:0] fifo_status_o
);
    rxh_flags_t       flags;
    logic [LVL_W-1:0] rx_level;
    logic             lvl_nonzero;
    logic             lvl_to_zero;
    logic             accept;
    logic             consume;

    assign rx_ready_o = rx_en_i && !flags.full && !rx_rst_i;
    assign accept     = rx_valid_i && rx_ready_o;
    assign consume    = rd_data_strobe_i && rx_en_i && lvl_nonzero && !rx_rst_i;

    rxh_level_ctr #(.LVL_W(LVL_W)) i_level (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (rx_rst_i),
        .inc_i     (accept),
        .dec_i     (consume),
        .level_o   (rx_level),
        .nonzero_o (lvl_nonzero),
        .to_zero_o (lvl_to_zero)
    );

    rxh_flag_reg i_flags (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (rx_rst_i),
        .load_i  (accept),
        .drain_i (consume),
        .last_i  (lvl_to_zero),
        .flags_o (flags)
    );

    rxh_data_reg #(.DATA_W(DATA_W)) i_data (
        .clk    (clk),
        .rst    (rst),
        .load_i (accept),
        .din_i  (rx_byte_i),
        .dout_o (rd_data_o)
    );

    rxh_status_pack #(
        .LVL_W  (LVL_W),
        .STAT_W (STAT_W),
        .RX_LSB (RX_LSB),
        .TX_LSB (TX_LSB)
    ) i_pack (
        .rx_level_i (rx_level),
        .tx_level_i (tx_level_i),
        .status_o   (fifo_status_o)
    );

    assign flag_full_o  = flags.full;
    assign flag_empty_o = flags.empty;
    assign flag_idle_o  = flags.idle;
endmodule

// File: rtl/uart_rx_hold_chk.sv
module uart_rx_hold_chk #(
    parameter int DATA_W = 8,
    parameter int LVL_W  = 5,
    parameter int STAT_W = 32,
    parameter int RX_LSB = 0,
    parameter int TX_LSB = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_valid_i,
    input logic [DATA_W-1:0] rx_byte_i,
    input logic              rx_ready_o,
    input logic              rd_data_strobe_i,
    input logic              rx_en_i,
    input logic              rx_rst_i,
    input logic [LVL_W-1:0]  tx_level_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              flag_full_o,
    input logic              flag_empty_o,
    input logic              flag_idle_o,
    input logic [STAT_W-1:0] fifo_status_o
);
    logic [LVL_W-1:0] lvl;
    logic             take;
    logic             drain;
    assign lvl   = fifo_status_o[RX_LSB +: LVL_W];
    assign take  = rx_valid_i && rx_ready_o;
    assign drain = rd_data_strobe_i && rx_en_i && (lvl != '0) && !rx_rst_i;

    // R1
    ready_gate_chk: assert property (@(posedge clk) disable iff (rst)
        rx_ready_o |-> (rx_en_i && !flag_full_o && !rx_rst_i));

    // R2
    load_flags_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> (flag_full_o && !flag_empty_o && !flag_idle_o
                  && rd_data_o == $past(rx_byte_i)));

    // R3
    no_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_full_o && !rx_rst_i) |=> $stable(rd_data_o));

    // R4
    drain_clears_full_chk: assert property (@(posedge clk) disable iff (rst)
        drain |=> (!flag_full_o && lvl == $past(lvl) - LVL_W'(1)));

    // R6
    ignored_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data_strobe_i && !drain && !take && !rx_rst_i)
        |=> ($stable(lvl) && $stable(flag_full_o) && $stable(flag_empty_o)));

    // R7
    tx_field_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_status_o[TX_LSB +: LVL_W] == tx_level_i);

    // R8
    rx_reset_chk: assert property (@(posedge clk) disable iff (rst)
        rx_rst_i |=> (lvl == '0 && !flag_full_o && flag_empty_o && flag_idle_o
                      && $stable(rd_data_o)));
endmodule

bind uart_rx_hold uart_rx_hold_chk #(
    .DATA_W (DATA_W),
    .LVL_W  (LVL_W),
    .STAT_W (STAT_W),
    .RX_LSB (RX_LSB),
    .TX_LSB (TX_LSB)
) i_uart_rx_hold_chk (
    .clk              (clk),
    .rst              (rst),
    .rx_valid_i       (rx_valid_i),
    .rx_byte_i        (rx_byte_i),
    .rx_ready_o       (rx_ready_o),
    .rd_data_strobe_i (rd_data_strobe_i),
    .rx_en_i          (rx_en_i),
    .rx_rst_i         (rx_rst_i),
    .tx_level_i       (tx_level_i),
    .rd_data_o        (rd_data_o),
    .flag_full_o      (flag_full_o),
    .flag_empty_o     (flag_empty_o),
    .flag_idle_o      (flag_idle_o),
    .fifo_status_o    (fifo_status_o)
);

// File: tb/test_uart_rx_hold.sv
module test_uart_rx_hold;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        rx_ready;
    logic        rd_strobe = 1'b0;
    logic        rx_en = 1'b0;
    logic        rx_rst = 1'b0;
    logic [4:0]  tx_level = 5'd0;
    logic [7:0]  rd_data;
    logic        f_full, f_empty, f_idle;
    logic [31:0] fstat;

    int tests_run = 0;
    int tests_failed = 0;

    // behavioural reference state
    int         m_lvl = 0;
    bit         m_full = 0, m_empty = 1, m_idle = 1;
    logic [7:0] m_data = 8'h00;

    always #5 clk = ~clk;

    uart_rx_hold i_uart_rx_hold (
        .clk              (clk),
        .rst              (rst),
        .rx_valid_i       (rx_valid),
        .rx_byte_i        (rx_byte),
        .rx_ready_o       (rx_ready),
        .rd_data_strobe_i (rd_strobe),
        .rx_en_i          (rx_en),
        .rx_rst_i         (rx_rst),
        .tx_level_i       (tx_level),
        .rd_data_o        (rd_data),
        .flag_full_o      (f_full),
        .flag_empty_o     (f_empty),
        .flag_idle_o      (f_idle),
        .fifo_status_o    (fstat)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        bit exp_ready;
        exp_ready = rx_en && !m_full && !rx_rst;
        check(tag, "R1 ready", {31'b0, rx_ready}, {31'b0, exp_ready});
        check(tag, "R3 rd_data", {24'b0, rd_data}, {24'b0, m_data});
        check(tag, "R2 full", {31'b0, f_full}, {31'b0, m_full});
        check(tag, "R5 empty", {31'b0, f_empty}, {31'b0, m_empty});
        check(tag, "R5 idle", {31'b0, f_idle}, {31'b0, m_idle});
        check(tag, "R7 status", fstat, (32'(tx_level) << 16) | 32'(m_lvl));
    endtask

    task automatic model_update;
        bit exp_ready;
        exp_ready = rx_en && !m_full && !rx_rst;
        if (rx_rst) begin
            m_lvl = 0; m_full = 0; m_empty = 1; m_idle = 1;
        end else begin
            if (rd_strobe && rx_en && m_lvl > 0) begin
                m_lvl = m_lvl - 1;
                m_full = 0;
                if (m_lvl == 0) begin
                    m_empty = 1; m_idle = 1;
                end
            end
            if (rx_valid && exp_ready) begin
                m_data = rx_byte;
                m_lvl = m_lvl + 1;
                m_full = 1; m_empty = 0; m_idle = 0;
            end
        end
    endtask

    // one cycle: drive at negedge, compare, advance model, wait for next negedge
    task automatic step(input logic v, input logic [7:0] b, input logic rd, input logic en,
                        input logic rr, input logic [4:0] tx, input string tag);
        rx_valid = v; rx_byte = b; rd_strobe = rd; rx_en = en; rx_rst = rr; tx_level = tx;
        #1;
        compare_all(tag);
        model_update();
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        tests_failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: state right after device reset
        step(0, 8'h00, 0, 0, 0, 5'd0, "R9");
        // R1: valid with receive disabled is refused
        step(1, 8'h3C, 0, 0, 0, 5'd2, "R1");
        step(0, 8'h00, 0, 0, 0, 5'd2, "R1");
        // R2: accept a byte
        step(1, 8'hA5, 0, 1, 0, 5'd3, "R2");
        step(0, 8'h00, 0, 1, 0, 5'd3, "R2");
        // R3: new bytes while full are held off
        step(1, 8'h5A, 0, 1, 0, 5'd4, "R3");
        step(1, 8'hFF, 0, 1, 0, 5'd4, "R3");
        // R6: read with receive disabled is ignored
        step(0, 8'h00, 1, 0, 0, 5'd1, "R6");
        step(0, 8'h00, 0, 1, 0, 5'd1, "R6");
        // R4, R5: consuming read drains to zero
        step(0, 8'h00, 1, 1, 0, 5'd7, "R4");
        step(0, 8'h00, 0, 1, 0, 5'd7, "R5");
        // R6: read at level zero is ignored
        step(0, 8'h00, 1, 1, 0, 5'd0, "R6");
        step(0, 8'h00, 0, 1, 0, 5'd0, "R6");
        // R8: receive reset while full, then with a byte offered in the same cycle
        step(1, 8'h81, 0, 1, 0, 5'd9, "R8");
        step(1, 8'h42, 1, 1, 1, 5'd9, "R8");
        step(1, 8'h24, 0, 1, 1, 5'd9, "R8");
        step(0, 8'h00, 0, 1, 0, 5'd9, "R8");
        // R7: extreme transmit level values
        step(0, 8'h00, 0, 1, 0, 5'd31, "R7");
        step(1, 8'h11, 0, 1, 0, 5'd16, "R7");
        step(0, 8'h00, 0, 1, 0, 5'd31, "R7");
        // mixed random traffic against the model
        for (int i = 0; i < 2000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0], r[15:8], r[1], (r[3:2] != 2'b00), (r[7:4] == 4'h0), r[20:16], "R2");
        end
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end
endmodule